// File: doc/BRIEF.md
# Fractional PLL Output Frequency Calculator

This block works out the output frequency of a fractional-N PLL from the reference frequency and the divider fields packed in two control words. A single start pulse captures the reference frequency, both control words and a mode select. Then a restoring divider produces the quotient one bit per clock. When the result is ready, the block raises a one-cycle done pulse and holds the result on its output.

There are two modes. In integer mode the output is the reference frequency times the feedback multiplier, divided by the pre-divider shifted left by the post-divider exponent. In fractional mode a signed 16-bit fraction joins the multiplier as its low sixteen bits, and the denominator is scaled by 65536 to match. A pre-divider of zero is reported as an error instead of being divided by.

Top module: `frac_pll_rate_calc`

## Requirements
- R1: Control word 0 carries the multiplier M in bits 21:12, the pre-divider P in bits 9:4 and the shift S in bits 2:0. Control word 1 carries the fraction K in bits 15:0 as a two's-complement value. All other bits are ignored.
- R2: With `frac_mode` low, the result is floor(fin*M / (P << S)), and K has no effect.
- R3: With `frac_mode` high, the result is floor(fin*(M*65536+K) / ((P*65536) << S)), with K signed.
- R4: The quotient is truncated, not rounded.
- R5: If P is zero, the done pulse follows the start edge by one cycle with `err` high and `fout_hz` zero, and `busy` does not rise.
- R6: For a nonzero P, `busy` is high from the cycle after the start edge until the done pulse. `done` rises exactly 64 clock edges after the start edge.
- R7: A start pulse that arrives while `busy` is high is ignored and does not change the result being computed.
- R8: `done` lasts one cycle. `fout_hz` and `err` hold their values until the next accepted start.
- R9: After reset, `busy`, `done` and `err` are low and `fout_hz` is zero.
- R10: In fractional mode, if M*65536+K is negative, the result is zero and `err` stays low.
- R11: The product is formed to full width, so a 32-bit reference times the largest multiplier gives an exact result wider than 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (only taken when idle) |
| frac_mode | input | 1 | 1 = fractional evaluation, 0 = integer |
| fin_hz | input | 32 | Reference frequency in Hz |
| ctrl0 | input | 32 | Control word holding M, P and S |
| ctrl1 | input | 32 | Control word holding K |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| err | output | 1 | Pre-divider was zero |
| fout_hz | output | 64 | Computed output frequency in Hz |

## Verification
The hardest state to reach from the ports is a second start pulse in the middle of a division. The bench launches a normal calculation, waits ten cycles, then pulses start with different fields and mode. It then checks that the result and the 64-edge latency both belong to the first request. Other cases that are hard to hit by chance are built directly: a negative combined multiplier (M zero with K at its most negative), a most-negative K on a nonzero M, and a full-scale reference with M at its maximum.

// File: rtl/frac_pll_rate_calc.sv
module frac_pll_rate_calc #(
  parameter int FIN_W = 32,
  parameter int Q_W   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             frac_mode,
  input  logic [FIN_W-1:0] fin_hz,
  input  logic [31:0]      ctrl0,
  input  logic [31:0]      ctrl1,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [Q_W-1:0]   fout_hz
);
  localparam int CNT_W = $clog2(Q_W + 1);
  localparam int MUL_W = 28;

  logic [9:0]  m_f;
  logic [5:0]  p_f;
  logic [2:0]  s_f;
  logic signed [15:0] k_f;
  assign m_f = ctrl0[21:12];
  assign p_f = ctrl0[9:4];
  assign s_f = ctrl0[2:0];
  assign k_f = ctrl1[15:0];

  logic signed [MUL_W-1:0] mul_frac;
  logic [MUL_W-1:0]        mul_sel;
  assign mul_frac = $signed({2'b00, m_f, 16'h0000}) + MUL_W'(k_f);
  assign mul_sel  = frac_mode ? (mul_frac[MUL_W-1] ? '0 : mul_frac)
                              : MUL_W'(m_f);

  logic [Q_W-1:0] num_w, den_w;
  assign num_w = Q_W'(fin_hz) * Q_W'(mul_sel);
  assign den_w = frac_mode ? (Q_W'({p_f, 16'h0000}) << s_f) : (Q_W'(p_f) << s_f);

  logic [Q_W-1:0]   den_q, quo_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [Q_W:0]     shifted, diff;
  assign shifted = {rem_q, quo_q[Q_W-1]};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      fout_hz <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (p_f == '0) begin
            done    <= 1'b1;
            err     <= 1'b1;
            fout_hz <= '0;
          end else begin
            busy  <= 1'b1;
            err   <= 1'b0;
            den_q <= den_w;
            quo_q <= num_w;
            rem_q <= '0;
            cnt_q <= CNT_W'(Q_W);
          end
        end
      end else begin
        if (!diff[Q_W]) begin
          rem_q <= diff[Q_W-1:0];
          quo_q <= {quo_q[Q_W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[Q_W-1:0];
          quo_q <= {quo_q[Q_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          fout_hz <= {quo_q[Q_W-2:0], ~diff[Q_W]};
        end
      end
    end
  end

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt_q == CNT_W'(Q_W));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> fout_hz == '0);
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(den_q) && cnt_q == $past(cnt_q) - 1'b1);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done) && busy) |-> $stable(fout_hz));
endmodule

// File: tb/frac_pll_rate_calc_tb.sv
module frac_pll_rate_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        mode;
    logic [31:0] fin;
    logic [31:0] c0;
    logic [31:0] c1;
    logic [63:0] exp_q;
  } vec_t;

  function automatic logic [31:0] mk0(int m, int p, int s);
    return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
  endfunction

  logic clk = 0, rst_n = 0, start = 0, frac_mode = 0;
  logic [31:0] fin_hz = 0, ctrl0 = 0, ctrl1 = 0;
  logic busy, done, err;
  logic [63:0] fout_hz;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_pll_rate_calc u_dut (.clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
    .fin_hz(fin_hz), .ctrl0(ctrl0), .ctrl1(ctrl1), .busy(busy), .done(done),
    .err(err), .fout_hz(fout_hz));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(logic md, logic [31:0] f, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    frac_mode = md; fin_hz = f; ctrl0 = a; ctrl1 = b; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vec_t tbl [NVEC];
    int cyc;
    // R3 R1: fractional with positive K
    tbl[0] = '{1'b1, 32'd24000000, mk0(173,2,1), 32'd16384, 64'd1039500000};
    // R3 R4: truncated fractional result
    tbl[1] = '{1'b1, 32'd24000000, mk0(262,2,3), 32'd9437, 64'd393215995};
    // R2: integer, K ignored
    tbl[2] = '{1'b0, 32'd24000000, mk0(225,3,0), 32'h0000_7fff, 64'd1800000000};
    // R2: integer with shift
    tbl[3] = '{1'b0, 32'd24000000, mk0(375,3,1), 32'd0, 64'd1500000000};
    // R3: most negative K
    tbl[4] = '{1'b1, 32'd24000000, mk0(200,3,0), 32'h0000_8000, 64'd1596000000};
    // R4: truncation in integer mode
    tbl[5] = '{1'b0, 32'd1000, mk0(1,3,0), 32'd0, 64'd333};
    // R10: negative combined multiplier
    tbl[6] = '{1'b1, 32'd24000000, mk0(0,1,0), 32'h0000_8000, 64'd0};
    // R11 R1: full-width product, unused bits set
    tbl[7] = '{1'b0, 32'hffff_ffff, mk0(1023,1,0) | 32'hffc0_0c08, 32'hffff_0000, 64'd4393751542785};

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0);
    check("R9 done", done, 0);
    check("R9 err", err, 0);
    check("R9 fout", fout_hz, 0);
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      launch(tbl[i].mode, tbl[i].fin, tbl[i].c0, tbl[i].c1);
      wait_done(cyc);
      check($sformatf("R2/R3 vec%0d fout", i), fout_hz, tbl[i].exp_q);
      check($sformatf("R6 vec%0d latency", i), 64'(cyc), 64'd64);
      check($sformatf("R10 vec%0d err", i), err, 0);
    end

    // R6 busy window
    launch(1'b0, 32'd24000000, mk0(300,3,1), 32'd0);
    check("R6 busy after start", busy, 1);
    wait_done(cyc);
    check("R6 busy low at done", busy, 0);
    // R8 single pulse and hold
    @(negedge clk);
    check("R8 done pulse", done, 0);
    repeat (5) @(negedge clk);
    check("R8 fout hold", fout_hz, 64'd1200000000);

    // R5 zero pre-divider
    launch(1'b1, 32'd24000000, mk0(100,0,2), 32'd5);
    check("R5 done next cycle", done, 1);
    check("R5 err", err, 1);
    check("R5 fout zero", fout_hz, 0);
    check("R5 busy low", busy, 0);
    repeat (3) @(negedge clk);
    check("R8 err hold", err, 1);

    // R7 start during busy
    launch(1'b0, 32'd24000000, mk0(350,3,2), 32'd0);
    repeat (9) @(negedge clk);
    frac_mode = 1; ctrl0 = mk0(173,2,1); ctrl1 = 32'd16384; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(cyc);
    check("R7 result of first request", fout_hz, 64'd700000000);
    check("R7 latency unchanged", 64'(cyc + 10), 64'd64);
    check("R7 err clear", err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule